// File: doc/BRIEF.md
# Microcontroller Interrupt Priority Controller

This block decides which interrupt a small microcontroller core services next. Five sources feed it: two external inputs, two timer overflows and one serial port. Each source has a pending flag that is set by a high cycle on its raw request line. Software controls the block through a small register write port. It can enable sources individually and globally, and it can raise any source to the high priority level. It can also clear pending flags by writing ones.

The core strobes `boundary_i` at each instruction boundary. On that cycle the block picks the winning eligible source. On the next clock it raises `taken_o` for one cycle with the vector number on `vec_o`. It also records which priority level is now in service.

On a return-from-interrupt strobe, the block retires the highest in-service level. It then refuses to take an interrupt on the very next boundary, so that the interrupted code always runs at least one instruction. A write to the enable or priority register is followed by the same one-boundary pause.

Timer and external flags clear themselves when their routine is vectored to. The serial flag does not. If software leaves the serial flag set, the serial routine is entered again after each single intervening instruction, which gives single-step execution.

All pins are plain control and status pins. There is no back-pressure: the core must accept `taken_o` on the cycle it appears.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After reset all pending flags, enables, priority bits and in-service levels are clear, and `taken_o` is low.
- R2: A high cycle on `irq_raw_i[i]` sets pending flag i. A flag whose source is disabled stays set, and it is serviced once the source is enabled again.
- R3: A source is eligible only when its pending flag, its enable bit (register 0, bits 4..0) and the global enable (register 0, bit 7) are all set.
- R4: Source indices, which are also the vector numbers, are external 0 = 0, timer 0 = 1, external 1 = 2, timer 1 = 3 and serial = 4. Among eligible sources at the same level, the lowest index wins.
- R5: A source whose priority bit is set (register 1, bits 4..0) is at the high level. Any eligible high-level source beats every low-level source, regardless of index.
- R6: After a return strobe, no interrupt is taken on the next boundary. A request that is still pending is taken on the boundary after that.
- R7: After a write to register 0 or register 1, no interrupt is taken on the next boundary.
- R8: `taken_o` is high for one clock, on the clock after a boundary that granted a source, and `vec_o` carries the vector number on that same clock.
- R9: The flags of sources 0 to 3 are cleared by hardware when their vector is taken. The serial flag (source 4) stays set, so the serial routine is re-entered after a one-instruction gap.
- R10: While a low-level routine is in service, only high-level sources may be taken. While a high-level routine is in service, nothing is taken.
- R11: A return strobe clears the high in-service level if it is set, and otherwise clears the low level.
- R12: Writing register 2 clears each pending flag whose data bit (bits 4..0) is 1. A raw request in the same cycle still sets the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_raw_i | input | 5 | Raw request lines, one per source |
| cfg_wr_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 2 | Register select: 0 enables, 1 priority, 2 flag clear |
| cfg_data_i | input | 8 | Register write data |
| boundary_i | input | 1 | Instruction boundary strobe from the core |
| reti_i | input | 1 | Return-from-interrupt strobe from the core |
| taken_o | output | 1 | One-clock pulse: an interrupt is being vectored |
| vec_o | output | 3 | Vector number, valid while `taken_o` is high |

## Verification
The assertions assume a well-behaved core. It never strobes `reti_i` in the same cycle as `boundary_i`, and it strobes `reti_i` only while some level is in service. The stimulus keeps to this: the random phase issues a return only on non-boundary cycles, and only when the bench's own model shows an in-service level. The directed phase pairs every return with an earlier vectoring. Raw requests, register writes and boundaries are otherwise random and can arrive together in any combination.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NSRC_DEF = 5;
  localparam logic [1:0] CFG_EN   = 2'd0;
  localparam logic [1:0] CFG_PRIO = 2'd1;
  localparam logic [1:0] CFG_CLR  = 2'd2;
  localparam int LVL_LO = 0;
  localparam int LVL_HI = 1;
endpackage

// File: rtl/irq_flags.sv
module irq_flags #(
  parameter int NSRC = 5,
  parameter logic [NSRC-1:0] AUTO_CLR = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] raw_i,
  input  logic [NSRC-1:0] sw_clr_i,
  input  logic [NSRC-1:0] take_hit_i,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] pend_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    logic clr;
    if (AUTO_CLR[i]) begin : g_auto
      assign clr = sw_clr_i[i] | take_hit_i[i];
      a_r9_auto_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (take_hit_i[i] && !raw_i[i]) |=> !pend_q[i]);
    end else begin : g_sticky
      assign clr = sw_clr_i[i];
      a_r9_serial_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (take_hit_i[i] && !sw_clr_i[i]) |=> pend_q[i]);
    end
    always_ff @(posedge clk) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= (pend_q[i] & ~clr) | raw_i[i];
    end
    a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      raw_i[i] |=> pend_q[i]);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int NSRC = 5,
  localparam int VW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] elig_i,
  input  logic [NSRC-1:0] prio_i,
  output logic            any_o,
  output logic            lvl_o,
  output logic [NSRC-1:0] grant_o,
  output logic [VW-1:0]   idx_o
);
  logic [NSRC-1:0] hi;
  logic [NSRC-1:0] cand;

  always_comb begin
    hi      = elig_i & prio_i;
    lvl_o   = |hi;
    cand    = lvl_o ? hi : elig_i;
    any_o   = |cand;
    grant_o = cand & ~(cand - NSRC'(1));
    idx_o   = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (cand[i]) idx_o = VW'(i);
    end
  end

  always_comb begin
    a_r4_grant_valid: assert ($onehot0(grant_o) && ((grant_o & ~elig_i) == '0));
  end
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boundary_i,
  input  logic       reti_i,
  input  logic       cfg_touch_i,
  input  logic       take_i,
  input  logic       take_lvl_i,
  output logic [1:0] isv_o,
  output logic       hold_o
);
  import irq_pkg::*;
  logic [1:0] isv_q;
  logic       reti_blk_q;
  logic       cfg_blk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isv_q      <= '0;
      reti_blk_q <= 1'b0;
      cfg_blk_q  <= 1'b0;
    end else begin
      logic [1:0] nxt;
      nxt = isv_q;
      if (reti_i) begin
        if (nxt[LVL_HI]) nxt[LVL_HI] = 1'b0;
        else             nxt[LVL_LO] = 1'b0;
      end
      if (take_i) nxt[take_lvl_i] = 1'b1;
      isv_q <= nxt;
      if (reti_i)          reti_blk_q <= 1'b1;
      else if (boundary_i) reti_blk_q <= 1'b0;
      if (cfg_touch_i)     cfg_blk_q  <= 1'b1;
      else if (boundary_i) cfg_blk_q  <= 1'b0;
    end
  end

  assign isv_o  = isv_q;
  assign hold_o = reti_blk_q | cfg_blk_q;

  a_r10_no_preempt_hi: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |-> !isv_q[LVL_HI]);
  a_r10_low_needs_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && isv_q[LVL_LO]) |-> take_lvl_i);
  a_r11_hi_first: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_i && isv_q[LVL_HI]) |=> (!isv_o[LVL_HI] && (isv_o[LVL_LO] == $past(isv_q[LVL_LO]))));
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl #(
  parameter int NSRC = 5,
  parameter logic [NSRC-1:0] AUTO_CLR = 5'b01111,
  parameter int DW = 8,
  localparam int VW = $clog2(NSRC)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_raw_i,
  input  logic            cfg_wr_i,
  input  logic [1:0]      cfg_addr_i,
  input  logic [DW-1:0]   cfg_data_i,
  input  logic            boundary_i,
  input  logic            reti_i,
  output logic            taken_o,
  output logic [VW-1:0]   vec_o
);
  import irq_pkg::*;

  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] prio_q;
  logic            gen_q;
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] sw_clr;
  logic [NSRC-1:0] lvl_mask;
  logic [NSRC-1:0] elig;
  logic [NSRC-1:0] grant;
  logic [NSRC-1:0] take_hit;
  logic [VW-1:0]   idx;
  logic            any;
  logic            lvl;
  logic            take;
  logic            hold;
  logic            cfg_touch;
  logic [1:0]      isv;
  logic            taken_q;
  logic [VW-1:0]   vec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      prio_q <= '0;
      gen_q  <= 1'b0;
    end else if (cfg_wr_i) begin
      if (cfg_addr_i == CFG_EN) begin
        en_q  <= cfg_data_i[NSRC-1:0];
        gen_q <= cfg_data_i[DW-1];
      end
      if (cfg_addr_i == CFG_PRIO) prio_q <= cfg_data_i[NSRC-1:0];
    end
  end

  assign cfg_touch = cfg_wr_i && (cfg_addr_i == CFG_EN || cfg_addr_i == CFG_PRIO);
  assign sw_clr    = (cfg_wr_i && cfg_addr_i == CFG_CLR) ? cfg_data_i[NSRC-1:0] : '0;

  always_comb begin
    if (isv[LVL_HI])      lvl_mask = '0;
    else if (isv[LVL_LO]) lvl_mask = prio_q;
    else                  lvl_mask = '1;
  end

  assign elig     = pend & en_q & {NSRC{gen_q}} & lvl_mask;
  assign take     = boundary_i & ~hold & any;
  assign take_hit = grant & {NSRC{take}};

  irq_flags #(.NSRC(NSRC), .AUTO_CLR(AUTO_CLR)) u_flags (
    .clk(clk), .rst_n(rst_n), .raw_i(irq_raw_i), .sw_clr_i(sw_clr),
    .take_hit_i(take_hit), .pend_o(pend));

  irq_arbiter #(.NSRC(NSRC)) u_arb (
    .elig_i(elig), .prio_i(prio_q), .any_o(any), .lvl_o(lvl),
    .grant_o(grant), .idx_o(idx));

  irq_inservice u_isv (
    .clk(clk), .rst_n(rst_n), .boundary_i(boundary_i), .reti_i(reti_i),
    .cfg_touch_i(cfg_touch), .take_i(take), .take_lvl_i(lvl),
    .isv_o(isv), .hold_o(hold));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken_q <= 1'b0;
      vec_q   <= '0;
    end else begin
      taken_q <= take;
      if (take) vec_q <= idx;
    end
  end

  assign taken_o = taken_q;
  assign vec_o   = vec_q;

  a_r8_taken_on_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> $past(boundary_i));
  a_r6_reti_gap: assert property (@(posedge clk) disable iff (!rst_n)
    reti_i ##1 boundary_i |=> !taken_o);
  a_r7_cfg_gap: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_touch ##1 boundary_i |=> !taken_o);
  a_r3_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (gen_q && ((grant & ~en_q) == '0)));
endmodule

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] raw = '0;
  logic       wr = 1'b0;
  logic [1:0] ad = '0;
  logic [7:0] dt = '0;
  logic       bnd = 1'b0;
  logic       rt = 1'b0;
  logic       taken;
  logic [2:0] vec;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  irq_prio_ctrl dut (
    .clk(clk), .rst_n(rst_n), .irq_raw_i(raw), .cfg_wr_i(wr), .cfg_addr_i(ad),
    .cfg_data_i(dt), .boundary_i(bnd), .reti_i(rt), .taken_o(taken), .vec_o(vec));

  always #2 clk = ~clk;

  // reference model state, built from the requirements
  logic [4:0] m_pend, m_en, m_prio;
  logic       m_gen, m_rblk, m_wblk;
  logic [1:0] m_isv;
  logic       e_take;
  logic [2:0] e_vec;

  function automatic logic [4:0] model_pick(output logic [2:0] v, output logic lv);
    logic [4:0] mask, el, hi, c;
    mask = m_isv[1] ? 5'b0 : (m_isv[0] ? m_prio : 5'b11111);
    el = m_pend & m_en & {5{m_gen}} & mask;
    hi = el & m_prio;
    lv = |hi;
    c  = lv ? hi : el;
    v  = 3'd0;
    for (int i = 4; i >= 0; i--) if (c[i]) v = 3'(i);
    return c;
  endfunction

  task automatic model_reset();
    m_pend = '0; m_en = '0; m_prio = '0; m_gen = 0;
    m_rblk = 0; m_wblk = 0; m_isv = '0; e_take = 0; e_vec = '0;
  endtask

  task automatic model_step();
    logic [4:0] c, clr;
    logic [2:0] v;
    logic lv, tk;
    c  = model_pick(v, lv);
    tk = bnd && !(m_rblk || m_wblk) && (c != 0);
    clr = '0;
    if (tk && v != 3'd4) clr[v] = 1'b1;
    if (wr && ad == 2'd2) clr = clr | dt[4:0];
    m_pend = (m_pend & ~clr) | raw;
    if (rt) begin
      if (m_isv[1]) m_isv[1] = 1'b0; else m_isv[0] = 1'b0;
    end
    if (tk) m_isv[lv] = 1'b1;
    m_rblk = rt ? 1'b1 : (bnd ? 1'b0 : m_rblk);
    m_wblk = (wr && ad < 2'd2) ? 1'b1 : (bnd ? 1'b0 : m_wblk);
    if (wr && ad == 2'd0) begin m_en = dt[4:0]; m_gen = dt[7]; end
    if (wr && ad == 2'd1) m_prio = dt[4:0];
    e_take = tk;
    if (tk) e_vec = v;
  endtask

  task automatic check(input bit ok, input string req, input string act, input string exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  // one clock: drive at negedge, sample 1 ns after the rising edge
  task automatic step(input logic [4:0] r, input logic b, input logic t,
                      input logic w, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    raw = r; bnd = b; rt = t; wr = w; ad = a; dt = d;
    model_step();
    @(posedge clk); #1;
    check(taken == e_take && (!e_take || vec == e_vec), "model",
          $sformatf("%0b/%0d", taken, vec), $sformatf("%0b/%0d", e_take, e_vec));
  endtask

  task automatic idle();               step('0, 0, 0, 0, '0, '0); endtask
  task automatic bd();                 step('0, 1, 0, 0, '0, '0); endtask
  task automatic ret();                step('0, 0, 1, 0, '0, '0); endtask
  task automatic req(input logic [4:0] r); step(r, 0, 0, 0, '0, '0); endtask
  task automatic wcfg(input logic [1:0] a, input logic [7:0] d); step('0, 0, 0, 1, a, d); endtask

  task automatic expect_out(input logic tk, input logic [2:0] v, input string req);
    check(taken == tk && (!tk || vec == v), req,
          $sformatf("%0b/%0d", taken, vec), $sformatf("%0b/%0d", tk, v));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d5));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    expect_out(0, 0, "R1");
    // disabled sources keep flags
    req(5'b01010); bd(); expect_out(0, 0, "R3");
    wcfg(2'd0, 8'h9F); bd(); expect_out(0, 0, "R7");
    bd(); expect_out(1, 1, "R4");          // timer 0 beats timer 1
    idle(); expect_out(0, 0, "R8");
    ret(); bd(); expect_out(0, 0, "R6");
    bd(); expect_out(1, 3, "R9");          // timer 0 flag auto-cleared
    ret(); bd(); bd(); expect_out(0, 0, "R9");
    // priority level override and preemption
    wcfg(2'd1, 8'h08); bd(); expect_out(0, 0, "R7");
    req(5'b01001); bd(); expect_out(1, 3, "R5");
    bd(); expect_out(0, 0, "R10");         // high level never preempted
    ret(); bd(); expect_out(0, 0, "R6");
    bd(); expect_out(1, 0, "R4");
    req(5'b01000); bd(); expect_out(1, 3, "R10");  // high preempts low
    ret(); bd(); req(5'b00100); bd(); expect_out(0, 0, "R11");  // low still active
    ret(); bd(); bd(); expect_out(1, 2, "R11");
    ret();
    // serial single-step behaviour
    req(5'b10000); bd(); expect_out(0, 0, "R6");
    bd(); expect_out(1, 4, "R9");
    ret(); bd(); expect_out(0, 0, "R6");
    bd(); expect_out(1, 4, "R9");
    ret(); wcfg(2'd2, 8'h10); bd(); bd(); expect_out(0, 0, "R12");
    // global enable, held flag
    wcfg(2'd0, 8'h1F); req(5'b00001); bd(); bd(); expect_out(0, 0, "R3");
    wcfg(2'd0, 8'h9F); bd(); bd(); expect_out(1, 0, "R2");
    ret();
    // clear and set in the same cycle: set wins
    step(5'b00100, 0, 0, 1, 2'd2, 8'h04); bd(); bd(); expect_out(1, 2, "R12");
    ret(); bd();
    // random phase against the model
    for (int n = 0; n < 4000; n++) begin
      logic [4:0] r;
      logic b, t, w;
      logic [1:0] a;
      logic [7:0] d;
      r = ($urandom % 6 == 0) ? 5'($urandom) : 5'b0;
      b = ($urandom % 2) == 1;
      t = !b && (m_isv != 0) && ($urandom % 5 == 0);
      w = ($urandom % 16) == 0;
      a = 2'($urandom % 3);
      d = 8'($urandom);
      if (a == 2'd0 && ($urandom % 4 != 0)) d[7] = 1'b1;
      step(r, b, t, w, a, d);
    end
    idle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule